// File: doc/BRIEF.md
# Received-Event Upload Poller

This block sits between a powerline code decoder and a host byte link. The decoder hands it one received code at a time, as a byte plus a flag telling whether the byte is a function or an address. The block keeps up to eight such bytes, together with a per-byte function/address bit. While the line is busy it raises a ring line to wake the host.

When reception on the line ends and at least one byte is stored, the block starts polling. It offers the poll code 0x5A on the transmit port at once, then again once every second. The second is measured by an internal divider of `TICKS_PER_SEC` clock cycles. Polling stops when the host sends the acknowledge code 0xC3. The block then sends a frame, which is not acknowledged. The frame is a size byte, a mask byte and the stored data bytes. After the frame the buffer is empty.

The decoder does not know which bytes are brightness or extended payload. The block therefore tracks the function it has just stored. It forces the mask bit to address (0) for the one byte after a dim or bright function, and for the two bytes after an extended-code function.

Top module: `evt_upload_poller`

## Requirements
- R1: After reset, `ring` is 0, `tx_valid` is 0 and the buffer is empty.
- R2: `ring` goes to 1 on the clock edge after `line_busy` rises, only when `ring_en` is 1. With `ring_en` at 0 it stays 0.
- R3: When `line_busy` falls and at least one byte is stored, the block offers 0x5A on `tx_data` from the next cycle. When `line_busy` falls and nothing is stored, no byte is sent.
- R4: Until the acknowledge arrives, 0x5A is offered again every `TICKS_PER_SEC` cycles. Host bytes other than 0xC3 have no effect on polling.
- R5: A host byte 0xC3 received while polling ends polling, releases `ring` and starts the upload on the next cycle. `ring` is also released when reception ends with nothing stored.
- R6: The frame is sent in this order: size byte, then mask, then data bytes in arrival order. The size byte equals the number of stored data bytes plus one. Exactly that many bytes follow it.
- R7: Mask bit i is 1 when data byte i is a function and 0 when it is an address. Bit 0 belongs to the first data byte, and unused bits are 0.
- R8: At most 8 data bytes are held. Events that arrive while 8 are held are dropped.
- R9: Function codes are read from the low nibble of a function byte. After a stored function with low nibble 0x4 (dim) or 0x5 (bright), the next stored byte gets mask bit 0. After low nibble 0x7 (extended code), the next two stored bytes get mask bit 0.
- R10: The buffer is empty once the last frame byte is accepted, and no poll follows. Events that arrive during the upload are dropped. A later frame holds only bytes stored after the upload.
- R11: A byte is taken only when `tx_valid` and `tx_ready` are both 1 on a clock edge. While `tx_ready` is 0 during the upload, `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_busy | input | 1 | High while a powerline reception is in progress |
| ring_en | input | 1 | Allows the ring line to be raised |
| evt_valid | input | 1 | A decoded code is present this cycle |
| evt_byte | input | 8 | Decoded code byte (housecode/unit or housecode/function) |
| evt_is_func | input | 1 | 1 when `evt_byte` is a function, 0 for an address |
| rx_valid | input | 1 | Host byte present this cycle |
| rx_data | input | 8 | Host byte |
| tx_ready | input | 1 | Link can take a byte this cycle |
| tx_valid | output | 1 | Byte offered on `tx_data` |
| tx_data | output | 8 | Byte to the host |
| ring | output | 1 | Wake-up line to the host |

## Verification
Directed receptions cover several cases. A mix of addresses and a bright function shows whether the mask follows the decoder flag and whether the payload byte is forced to address. An eleven-event burst tells correct dropping apart from overwriting. An extended-code function followed by flagged bytes shows whether the two-byte payload window is right. An empty reception and a reception with ring disabled show that polling is not started and that the ring is gated. Random receptions of 1 to 11 events are checked against a reference model of the frame, with random transmit back-pressure and a stray event during the upload. These separate frame-order and mask-position faults from handshake faults.

// File: rtl/evt_upload_pkg.sv
// Shared constants and types for the received-event upload poller.
package evt_upload_pkg;

    // Link side states of the upload controller.
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_POLL = 2'd1,
        LK_SEND = 2'd2
    } link_state_t;

    localparam logic [7:0] POLL_CODE = 8'h5A;
    localparam logic [7:0] ACK_CODE  = 8'hC3;

    localparam logic [3:0] FN_DIM    = 4'h4;
    localparam logic [3:0] FN_BRIGHT = 4'h5;
    localparam logic [3:0] FN_EXT    = 4'h7;

    // Number of payload bytes that trail a function code.
    function automatic logic [1:0] trailer_len(input logic [3:0] fn);
        logic [1:0] n;
        n = 2'd0;
        if (fn == FN_DIM || fn == FN_BRIGHT) n = 2'd1;
        else if (fn == FN_EXT)               n = 2'd2;
        return n;
    endfunction

endpackage

// File: rtl/evt_tick_div.sv
// One-second tick divider.
// Counts clock cycles while run is high and pulses tick for one cycle
// every PERIOD cycles. The count restarts from zero whenever run is low.
// Assumes PERIOD >= 2.
module evt_tick_div #(
    parameter int unsigned PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    // Free-running cycle count inside the polling window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    // R4: ticks never come back to back
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/evt_store.sv
// Received-event store.
// Holds up to DEPTH code bytes in arrival order with one function/address
// bit each. A function byte whose low nibble is dim, bright or extended
// opens a payload window, and bytes stored inside it get mask bit 0.
// Writes are ignored when store_en is low, when the store is full, or in
// the cycle of clr. Assumes DEPTH <= 8 so that the mask fits one byte.
module evt_store
    import evt_upload_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNTW = $clog2(DEPTH + 1),
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            store_en,
    input  logic            clr,
    input  logic            evt_valid,
    input  logic [7:0]      evt_byte,
    input  logic            evt_is_func,
    input  logic [IW-1:0]   rd_idx,
    output logic [7:0]      rd_byte,
    output logic [7:0]      mask_byte,
    output logic [CNTW-1:0] count
);
    localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

    logic [7:0]       slot [DEPTH];
    logic [DEPTH-1:0] mask_q;
    logic [DEPTH-1:0] slot_we;
    logic [1:0]       follow;
    logic             wr;
    logic             fn_eff;

    assign wr     = evt_valid && store_en && !clr && (count < FULL);
    assign fn_eff = evt_is_func && (follow == 2'd0);

    // One write enable per slot, selected by the fill count.
    for (genvar s = 0; s < DEPTH; s++) begin : g_we
        assign slot_we[s] = wr && (count == CNTW'(s));
    end

    // Data slots: written once each per buffer fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) slot[s] <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (slot_we[s]) slot[s] <= evt_byte;
            end
        end
    end

    // Mask bits: cleared with the buffer, set per slot on write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mask_q <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (slot_we[s]) mask_q[s] <= fn_eff;
            end
        end
    end

    // Fill count: advances on each stored byte, empties on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (wr) begin
            count <= count + 1'b1;
        end
    end

    // Payload window: counts bytes still owed to the last function.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            follow <= 2'd0;
        end else if (wr) begin
            if (follow != 2'd0) follow <= follow - 2'd1;
            else if (fn_eff)    follow <= trailer_len(evt_byte[3:0]);
            else                follow <= 2'd0;
        end
    end

    // Read port and padded mask byte for the frame.
    always_comb begin
        rd_byte = '0;
        if (32'(rd_idx) < DEPTH) rd_byte = slot[rd_idx];
        mask_byte = '0;
        mask_byte[DEPTH-1:0] = mask_q;
    end

    // R8: the fill count never passes the capacity
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    // R8: an event offered to a full store leaves the count unchanged
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL && evt_valid && !clr) |=> count == FULL);

    // R10: a clear empties the store
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0 && mask_byte == 8'h00);

    // R9: a byte stored inside a payload window is never marked function
    a_r9_window: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && follow != 2'd0) |=> !mask_byte[$past(count)]);

endmodule

// File: rtl/evt_link_fsm.sv
// Link controller.
// Idle until reception ends with bytes stored. It then offers the poll
// code, and offers it again on every tick until the host acknowledges.
// After that it streams size, mask and data bytes over a valid/ready
// port and clears the store after the last byte. Assumes count does not
// change between the start of the upload and its end (store_en is low).
module evt_link_fsm
    import evt_upload_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNTW = $clog2(DEPTH + 1),
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned FW   = $clog2(DEPTH + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy_fall,
    input  logic [CNTW-1:0] count,
    input  logic [7:0]      mask_byte,
    input  logic [7:0]      rd_byte,
    input  logic            rx_valid,
    input  logic [7:0]      rx_data,
    input  logic            tick,
    input  logic            tx_ready,
    output logic            tx_valid,
    output logic [7:0]      tx_data,
    output logic [IW-1:0]   rd_idx,
    output logic            poll_run,
    output logic            clr,
    output logic            store_en,
    output logic            ack_seen,
    output logic            end_empty
);
    link_state_t   state;
    logic          pending;
    logic [FW-1:0] idx;
    logic [FW-1:0] last_idx;
    logic          accept;

    assign accept    = tx_valid && tx_ready;
    assign last_idx  = FW'(count) + FW'(1);
    assign ack_seen  = (state == LK_POLL) && rx_valid && (rx_data == ACK_CODE);
    assign end_empty = busy_fall && (count == '0);
    assign poll_run  = (state == LK_POLL);
    assign store_en  = (state != LK_SEND);
    assign clr       = (state == LK_SEND) && accept && (idx == last_idx);
    assign rd_idx    = IW'(idx - FW'(2));

    // State, poll-pending flag and frame index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= LK_IDLE;
            pending <= 1'b0;
            idx     <= '0;
        end else begin
            case (state)
                LK_IDLE: begin
                    if (busy_fall && count != '0) begin
                        state   <= LK_POLL;
                        pending <= 1'b1;
                    end
                end
                LK_POLL: begin
                    if (ack_seen) begin
                        state   <= LK_SEND;
                        pending <= 1'b0;
                        idx     <= '0;
                    end else if (tick) begin
                        pending <= 1'b1;
                    end else if (accept) begin
                        pending <= 1'b0;
                    end
                end
                LK_SEND: begin
                    if (accept) begin
                        if (idx == last_idx) state <= LK_IDLE;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                default: state <= LK_IDLE;
            endcase
        end
    end

    // Byte offered on the link in the current state.
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        case (state)
            LK_POLL: begin
                tx_valid = pending;
                tx_data  = POLL_CODE;
            end
            LK_SEND: begin
                tx_valid = 1'b1;
                if (idx == '0)              tx_data = 8'(count) + 8'd1;
                else if (idx == FW'(1))     tx_data = mask_byte;
                else                        tx_data = rd_byte;
            end
            default: ;
        endcase
    end

    // R5: an acknowledge starts the frame with the size byte
    a_r5_ack_starts: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |=> (tx_valid && tx_data == 8'($past(count)) + 8'd1));

    // R4: each tick during polling brings a fresh poll offer
    a_r4_poll_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_POLL && tick && !ack_seen) |=> (tx_valid && tx_data == POLL_CODE));

    // R11: an offered byte is held while the link stalls
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !ack_seen) |=> (tx_valid && $stable(tx_data)));

    // R3: nothing is offered while idle with an empty store
    a_r3_quiet_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_IDLE && count == '0 && !busy_fall) |=> !tx_valid);

endmodule

// File: rtl/evt_upload_poller.sv
// Received-event upload poller (top).
// Buffers decoded powerline codes, raises a wake-up ring at the start of
// reception, polls the host once per TICKS_PER_SEC cycles after reception
// ends, and uploads a length-prefixed frame with a function/address mask
// after the host acknowledges. Assumes no event arrives in the same cycle
// that line_busy falls.
module evt_upload_poller
    import evt_upload_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 4800000,
    parameter int unsigned DEPTH         = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_busy,
    input  logic       ring_en,
    input  logic       evt_valid,
    input  logic [7:0] evt_byte,
    input  logic       evt_is_func,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       ring
);
    localparam int unsigned CNTW = $clog2(DEPTH + 1);
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic            busy_q;
    logic            busy_rise;
    logic            busy_fall;
    logic            tick;
    logic            poll_run;
    logic            clr;
    logic            store_en;
    logic            ack_seen;
    logic            end_empty;
    logic [CNTW-1:0] count;
    logic [7:0]      mask_byte;
    logic [7:0]      rd_byte;
    logic [IW-1:0]   rd_idx;

    // Edge detector on the reception indicator.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= line_busy;
    end

    assign busy_rise = line_busy && !busy_q;
    assign busy_fall = busy_q && !line_busy;

    // Wake-up ring: set at reception start, released by ack or empty end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring <= 1'b0;
        end else if (busy_rise && ring_en) begin
            ring <= 1'b1;
        end else if (ack_seen || end_empty) begin
            ring <= 1'b0;
        end
    end

    evt_tick_div #(
        .PERIOD (TICKS_PER_SEC)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (poll_run),
        .tick  (tick)
    );

    evt_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_en    (store_en),
        .clr         (clr),
        .evt_valid   (evt_valid),
        .evt_byte    (evt_byte),
        .evt_is_func (evt_is_func),
        .rd_idx      (rd_idx),
        .rd_byte     (rd_byte),
        .mask_byte   (mask_byte),
        .count       (count)
    );

    evt_link_fsm #(
        .DEPTH (DEPTH)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_fall (busy_fall),
        .count     (count),
        .mask_byte (mask_byte),
        .rd_byte   (rd_byte),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tick      (tick),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .rd_idx    (rd_idx),
        .poll_run  (poll_run),
        .clr       (clr),
        .store_en  (store_en),
        .ack_seen  (ack_seen),
        .end_empty (end_empty)
    );

    // R2: the ring only rises when it was enabled
    a_r2_ring_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring) |-> $past(ring_en));

    // R5: an acknowledge releases the ring
    a_r5_ring_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_seen && !busy_rise) |=> !ring);

endmodule

// File: tb/evt_upload_poller_test.sv
module evt_upload_poller_test;
    localparam int T = 40;
    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_busy = 1'b0;
    logic       ring_en = 1'b1;
    logic       evt_valid = 1'b0;
    logic [7:0] evt_byte = 8'h00;
    logic       evt_is_func = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_ready = 1'b1;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       ring;

    always #2 clk = ~clk;

    evt_upload_poller #(.TICKS_PER_SEC(T), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .line_busy(line_busy), .ring_en(ring_en),
        .evt_valid(evt_valid), .evt_byte(evt_byte), .evt_is_func(evt_is_func),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .ring(ring)
    );

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int cap_b[$];
    int cap_t[$];
    int exp_q[$];
    int ev_b[16];
    bit ev_f[16];
    int ev_n;
    bit hold_v = 1'b0;
    logic [7:0] hold_d;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Link monitor: records accepted bytes and checks R11 holding.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (hold_v) chk(tx_valid && tx_data == hold_d, "R11 hold", tx_data, hold_d);
            if (tx_valid && tx_ready) begin
                cap_b.push_back(int'(tx_data));
                cap_t.push_back(cyc);
            end
            hold_v = tx_valid && !tx_ready && uut.u_link.state == 2'd2 ? 1'b0 : 1'b0;
            hold_v = tx_valid && !tx_ready;
            hold_d = tx_data;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic put_event(input logic [7:0] b, input bit f);
        evt_valid = 1'b1; evt_byte = b; evt_is_func = f;
        step(1);
        evt_valid = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        step(1);
        rx_valid = 1'b0;
    endtask

    // Reference frame built from the requirements (R6..R9).
    task automatic build_exp();
        int cnt, fol, msk;
        int dat[$];
        cnt = 0; fol = 0; msk = 0;
        exp_q.delete();
        for (int i = 0; i < ev_n; i++) begin
            if (cnt < D) begin
                bit fe;
                int nib;
                fe = ev_f[i] && (fol == 0);
                nib = ev_b[i] & 15;
                if (fol != 0) fol--;
                else if (fe && (nib == 4 || nib == 5)) fol = 1;
                else if (fe && nib == 7) fol = 2;
                else fol = 0;
                if (fe) msk |= (1 << cnt);
                dat.push_back(ev_b[i]);
                cnt++;
            end
        end
        if (cnt > 0) begin
            exp_q.push_back(cnt + 1);
            exp_q.push_back(msk);
            foreach (dat[i]) exp_q.push_back(dat[i]);
        end
    endtask

    task automatic wait_cap(input int n, input int limit);
        int k;
        k = 0;
        while (cap_b.size() < n && k < limit) begin
            step(1);
            k++;
        end
    endtask

    // One reception: ring check, events, end of reception.
    task automatic reception(input bit gap);
        cap_b.delete(); cap_t.delete();
        line_busy = 1'b1;
        step(1);
        chk(ring == ring_en, "R2 ring at reception start", ring, ring_en);
        for (int i = 0; i < ev_n; i++) begin
            put_event(8'(ev_b[i]), ev_f[i]);
            if (gap) step($urandom_range(0, 2));
        end
        line_busy = 1'b0;
        step(1);
    endtask

    // Acknowledge a poll and collect the frame.
    task automatic ack_and_collect(input bit rand_ready, input bit stray, input string tag);
        step(3);
        cap_b.delete(); cap_t.delete();
        send_rx(8'hC3);
        chk(ring == 1'b0, "R5 ring released on ack", ring, 0);
        if (stray) begin
            tx_ready = 1'b0;
            put_event(8'h11, 1'b0);
            put_event(8'h22, 1'b1);
        end
        begin
            int k;
            k = 0;
            while (cap_b.size() < exp_q.size() && k < 400) begin
                tx_ready = rand_ready ? 1'($urandom_range(0, 1)) : 1'b1;
                step(1);
                k++;
            end
        end
        tx_ready = 1'b1;
        step(2 * T + 5);
        chk(cap_b.size() == exp_q.size(), "R10 frame length, no poll after clear",
            cap_b.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < cap_b.size(); i++) begin
            if (i == 0)      chk(cap_b[i] == exp_q[i], "R6 size byte", cap_b[i], exp_q[i]);
            else if (i == 1) chk(cap_b[i] == exp_q[i], "R7 mask byte", cap_b[i], exp_q[i]);
            else             chk(cap_b[i] == exp_q[i], tag, cap_b[i], exp_q[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5151));
        step(3);
        // R1: reset state
        chk(ring == 1'b0, "R1 ring after reset", ring, 0);
        chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
        rst_n = 1'b1;
        step(2);
        chk(tx_valid == 1'b0, "R1 idle after reset release", tx_valid, 0);

        // Directed: addresses, bright with payload flagged as function (R9).
        ev_n = 4;
        ev_b[0] = 8'h66; ev_f[0] = 0;
        ev_b[1] = 8'h6E; ev_f[1] = 0;
        ev_b[2] = 8'hE5; ev_f[2] = 1;
        ev_b[3] = 8'h58; ev_f[3] = 1;
        build_exp();
        reception(1'b0);
        wait_cap(1, 5);
        chk(cap_b.size() == 1 && cap_b[0] == 8'h5A, "R3 first poll byte",
            cap_b.size() > 0 ? cap_b[0] : -1, 8'h5A);
        step(3);
        send_rx(8'h00);   // R4: non-ack bytes are ignored
        send_rx(8'h5A);
        wait_cap(3, 4 * T);
        chk(cap_b.size() == 3, "R4 polling continues after other bytes", cap_b.size(), 3);
        if (cap_b.size() == 3) begin
            chk(cap_t[1] - cap_t[0] == T, "R4 poll period", cap_t[1] - cap_t[0], T);
            chk(cap_t[2] - cap_t[1] == T, "R4 poll period", cap_t[2] - cap_t[1], T);
            chk(cap_b[2] == 8'h5A, "R4 repeated poll code", cap_b[2], 8'h5A);
        end
        chk(ring == 1'b1, "R2 ring held while polling", ring, 1);
        ack_and_collect(1'b0, 1'b0, "R9 bright payload");
        chk(exp_q[1] == 8'h04, "R9 expected mask with forced payload", exp_q[1], 8'h04);

        // Overflow: 11 events, only 8 stored (R8).
        ev_n = 11;
        for (int i = 0; i < 11; i++) begin ev_b[i] = 8'h60 + i * 16 + 1; ev_f[i] = 0; end
        ev_b[9] = 8'h99; ev_b[10] = 8'hAA;
        build_exp();
        reception(1'b1);
        wait_cap(1, 5);
        ack_and_collect(1'b1, 1'b0, "R8 overflow data");
        chk(exp_q[0] == 9, "R8 size after overflow", exp_q[0], 9);

        // Extended code followed by two flagged bytes (R9), stray events during upload (R10).
        ev_n = 5;
        ev_b[0] = 8'hA7; ev_f[0] = 1;
        ev_b[1] = 8'h03; ev_f[1] = 1;
        ev_b[2] = 8'hFF; ev_f[2] = 1;
        ev_b[3] = 8'hA2; ev_f[3] = 1;
        ev_b[4] = 8'h6A; ev_f[4] = 0;
        build_exp();
        reception(1'b1);
        wait_cap(1, 5);
        ack_and_collect(1'b1, 1'b1, "R9 extended payload");
        chk(exp_q[1] == 8'h09, "R9 expected mask for extended", exp_q[1], 8'h09);

        // Empty reception: ring released, no poll (R3, R5).
        ev_n = 0;
        reception(1'b0);
        step(1);
        chk(ring == 1'b0, "R5 ring released on empty end", ring, 0);
        step(2 * T);
        chk(cap_b.size() == 0, "R3 no poll for empty buffer", cap_b.size(), 0);

        // Ring disabled (R2); frame still delivered, only new bytes (R10).
        ring_en = 1'b0;
        ev_n = 2;
        ev_b[0] = 8'h26; ev_f[0] = 0;
        ev_b[1] = 8'h23; ev_f[1] = 1;
        build_exp();
        reception(1'b0);
        chk(ring == 1'b0, "R2 ring stays low when disabled", ring, 0);
        wait_cap(1, 5);
        chk(cap_b.size() == 1, "R3 poll with ring disabled", cap_b.size(), 1);
        ack_and_collect(1'b1, 1'b0, "R10 only new bytes");
        ring_en = 1'b1;

        // Random receptions against the reference frame (R6, R7, R8, R9).
        for (int r = 0; r < 8; r++) begin
            ev_n = $urandom_range(1, 11);
            for (int i = 0; i < ev_n; i++) begin
                int pick;
                pick = $urandom_range(0, 3);
                ev_b[i] = $urandom_range(0, 255);
                if (pick == 0) ev_b[i] = (ev_b[i] & 8'hF0) | (4 + $urandom_range(0, 1));
                if (pick == 1) ev_b[i] = (ev_b[i] & 8'hF0) | 7;
                ev_f[i] = 1'($urandom_range(0, 1));
            end
            build_exp();
            reception(1'b1);
            wait_cap(1, 5);
            ack_and_collect(1'b1, r == 3, "R6 random frame data");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule